// File: doc/BRIEF.md
# Adjustable Time-of-Day and Alarm Registers

This block keeps a running time of day and a separate alarm setting. The time of day holds seconds, minutes and hours. The seconds count is kept inside the block, and only hours and minutes appear at the ports. The alarm setting holds hours and minutes. Both are shown as 24-hour HH:MM values from 00:00 to 23:59, and both start at 00:00 after reset.

A controller outside the block chooses one of four editable fields with a 2-bit select. It then pulses a one-cycle increment or decrement strobe to step that field by one. Every field wraps around within its own range. A manual edit never moves a neighbouring field. The running clock advances on a 1 Hz tick, and only while the run input is high.

A combinational flag shows when the time of day and the alarm agree in both hours and minutes. The surrounding logic uses this flag to raise its alarm. Display decoding, button conditioning and mode sequencing are not part of this block.

Top module: `tod_alarm_regs`

## Requirements
- R1: After reset, time hours, time minutes, internal seconds, alarm hours and alarm minutes are all 0. The match flag is therefore 1.
- R2: On each cycle with `tick_1hz`=1 and `run_mode`=1, seconds advance by one. Second 59 rolls to 0 and carries into minutes, minute 59 rolls to 0 and carries into hours, and 23:59:59 becomes 00:00:00.
- R3: Field select codes are: 0 = time minute, 1 = time hour, 2 = alarm minute, 3 = alarm hour. A minute field steps by one per strobe, wrapping 59 to 0 on increment and 0 to 59 on decrement.
- R4: An hour field steps by one per strobe, wrapping 23 to 0 on increment and 0 to 23 on decrement.
- R5: A manual minute edit that wraps causes no carry or borrow into the hour field of the same register.
- R6: Editing either alarm field leaves the time of day (hours, minutes, seconds) exactly as the tick and run inputs alone would leave it.
- R7: A time-minute edit sets seconds to 0. A time-hour edit leaves seconds unchanged.
- R8: While `run_mode`=0, ticks are ignored and the time of day holds.
- R9: A cycle with both `inc_stb` and `dec_stb` high changes no field.
- R10: `alm_match` is 1 exactly when time hours equal alarm hours and time minutes equal alarm minutes.
- R11: When a time-field edit and a tick arrive in the same cycle, the edit is applied and that tick is dropped. A tick that coincides with an alarm-field edit still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| run_mode | input | 1 | 1 lets the time of day advance on ticks |
| fld_sel | input | 2 | Field chosen for editing (encoding in R3) |
| inc_stb | input | 1 | One-cycle step-up strobe for the selected field |
| dec_stb | input | 1 | One-cycle step-down strobe for the selected field |
| cur_hr | output | 5 | Time-of-day hours, 0 to 23 |
| cur_min | output | 6 | Time-of-day minutes, 0 to 59 |
| alm_hr | output | 5 | Alarm hours, 0 to 23 |
| alm_min | output | 6 | Alarm minutes, 0 to 59 |
| alm_match | output | 1 | Time of day equals the alarm in hours and minutes |

## Verification
The assertions assume three things about the inputs:
- Strobes and ticks are single-cycle pulses, sampled only at the rising edge.
- `fld_sel` is valid in every cycle that carries a strobe.
- An edit and a tick may coincide.

For that last case, the check that alarm edits leave the time alone is limited to cycles with no tick, because a coincident tick is allowed to advance the time.

The stimulus drives every input just after a falling edge and holds it for exactly one rising edge. Edits, ticks and the cases where both strobes or an edit and a tick are high together are placed deliberately, so each case in R9 and R11 lands in a known cycle.

// File: rtl/tar_pkg.sv
package tar_pkg;

    // Field select codes seen on fld_sel
    typedef enum logic [1:0] {
        FLD_TMIN = 2'd0,
        FLD_THR  = 2'd1,
        FLD_AMIN = 2'd2,
        FLD_AHR  = 2'd3
    } fld_e;

    localparam int NUM_FLD = 4;

    // Resolved step request for one field
    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

endpackage

// File: rtl/wrap_step.sv
// Modulo up/down stepper: combinational next value for one field
module wrap_step #(
    parameter int MODULUS = 60,
    parameter int W       = $clog2(MODULUS)
) (
    input  logic [W-1:0] val,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    always_comb begin
        nxt = val;
        if (up && !dn) begin
            nxt = (val == TOP) ? '0 : val + W'(1);
        end else if (dn && !up) begin
            nxt = (val == '0) ? TOP : val - W'(1);
        end
    end

endmodule

// File: rtl/tod_counter.sv
// Running time of day: seconds -> minutes -> hours, with manual edits
module tod_counter
    import tar_pkg::*;
#(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int HR_MOD  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       run,
    input  step_t                      min_adj,
    input  step_t                      hr_adj,
    output logic [$clog2(SEC_MOD)-1:0] sec_o,
    output logic [$clog2(MIN_MOD)-1:0] min_o,
    output logic [$clog2(HR_MOD)-1:0]  hr_o
);

    localparam int SW = $clog2(SEC_MOD);
    localparam int MW = $clog2(MIN_MOD);
    localparam int HW = $clog2(HR_MOD);

    typedef struct packed {
        logic [HW-1:0] hr;
        logic [MW-1:0] min;
        logic [SW-1:0] sec;
    } tod_t;

    tod_t st_q, st_d;

    logic          min_edit, any_edit, adv, sec_carry, min_carry;
    logic [SW-1:0] sec_nx;
    logic [MW-1:0] min_nx;
    logic [HW-1:0] hr_nx;

    assign min_edit  = min_adj.up | min_adj.dn;
    assign any_edit  = min_edit | hr_adj.up | hr_adj.dn;
    // a tick that coincides with a time edit is dropped
    assign adv       = tick & run & ~any_edit;
    assign sec_carry = adv && (st_q.sec == SW'(SEC_MOD - 1));
    assign min_carry = sec_carry && (st_q.min == MW'(MIN_MOD - 1));

    wrap_step #(.MODULUS(SEC_MOD), .W(SW)) u_sec (
        .val (st_q.sec),
        .up  (adv),
        .dn  (1'b0),
        .nxt (sec_nx)
    );

    wrap_step #(.MODULUS(MIN_MOD), .W(MW)) u_min (
        .val (st_q.min),
        .up  (sec_carry | min_adj.up),
        .dn  (min_adj.dn),
        .nxt (min_nx)
    );

    wrap_step #(.MODULUS(HR_MOD), .W(HW)) u_hr (
        .val (st_q.hr),
        .up  (min_carry | hr_adj.up),
        .dn  (hr_adj.dn),
        .nxt (hr_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sec = min_edit ? '0 : sec_nx;
        st_d.min = min_nx;
        st_d.hr  = hr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;
    assign min_o = st_q.min;
    assign hr_o  = st_q.hr;

endmodule

// File: rtl/alarm_store.sv
// Alarm setting: minutes and hours, edited independently
module alarm_store
    import tar_pkg::*;
#(
    parameter int MIN_MOD = 60,
    parameter int HR_MOD  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  step_t                      min_adj,
    input  step_t                      hr_adj,
    output logic [$clog2(MIN_MOD)-1:0] min_o,
    output logic [$clog2(HR_MOD)-1:0]  hr_o
);

    localparam int MW = $clog2(MIN_MOD);
    localparam int HW = $clog2(HR_MOD);

    typedef struct packed {
        logic [HW-1:0] hr;
        logic [MW-1:0] min;
    } alm_t;

    alm_t          st_q, st_d;
    logic [MW-1:0] min_nx;
    logic [HW-1:0] hr_nx;

    wrap_step #(.MODULUS(MIN_MOD), .W(MW)) u_min (
        .val (st_q.min),
        .up  (min_adj.up),
        .dn  (min_adj.dn),
        .nxt (min_nx)
    );

    wrap_step #(.MODULUS(HR_MOD), .W(HW)) u_hr (
        .val (st_q.hr),
        .up  (hr_adj.up),
        .dn  (hr_adj.dn),
        .nxt (hr_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.min = min_nx;
        st_d.hr  = hr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign min_o = st_q.min;
    assign hr_o  = st_q.hr;

endmodule

// File: rtl/tod_alarm_regs.sv
// Top: field decode, time-of-day counter, alarm store, match flag
module tod_alarm_regs
    import tar_pkg::*;
#(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int HR_MOD  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_1hz,
    input  logic                       run_mode,
    input  logic [1:0]                 fld_sel,
    input  logic                       inc_stb,
    input  logic                       dec_stb,
    output logic [$clog2(HR_MOD)-1:0]  cur_hr,
    output logic [$clog2(MIN_MOD)-1:0] cur_min,
    output logic [$clog2(HR_MOD)-1:0]  alm_hr,
    output logic [$clog2(MIN_MOD)-1:0] alm_min,
    output logic                       alm_match
);

    localparam int SW = $clog2(SEC_MOD);

    logic [NUM_FLD-1:0] up_v, dn_v;
    step_t              tmin_adj, thr_adj, amin_adj, ahr_adj;
    logic [SW-1:0]      tod_sec;

    // one step per field; both strobes together cancel
    for (genvar f = 0; f < NUM_FLD; f++) begin : g_dec
        assign up_v[f] = inc_stb & ~dec_stb & (fld_sel == 2'(f));
        assign dn_v[f] = dec_stb & ~inc_stb & (fld_sel == 2'(f));
    end

    assign tmin_adj = {up_v[FLD_TMIN], dn_v[FLD_TMIN]};
    assign thr_adj  = {up_v[FLD_THR],  dn_v[FLD_THR]};
    assign amin_adj = {up_v[FLD_AMIN], dn_v[FLD_AMIN]};
    assign ahr_adj  = {up_v[FLD_AHR],  dn_v[FLD_AHR]};

    tod_counter #(
        .SEC_MOD (SEC_MOD),
        .MIN_MOD (MIN_MOD),
        .HR_MOD  (HR_MOD)
    ) u_tod (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .run     (run_mode),
        .min_adj (tmin_adj),
        .hr_adj  (thr_adj),
        .sec_o   (tod_sec),
        .min_o   (cur_min),
        .hr_o    (cur_hr)
    );

    alarm_store #(
        .MIN_MOD (MIN_MOD),
        .HR_MOD  (HR_MOD)
    ) u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .min_adj (amin_adj),
        .hr_adj  (ahr_adj),
        .min_o   (alm_min),
        .hr_o    (alm_hr)
    );

    assign alm_match = (cur_hr == alm_hr) && (cur_min == alm_min);

endmodule

// File: rtl/tar_chk.sv
// Property checker, attached to tod_alarm_regs by bind
module tar_chk #(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int HR_MOD  = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_1hz,
    input logic                       run_mode,
    input logic [1:0]                 fld_sel,
    input logic                       inc_stb,
    input logic                       dec_stb,
    input logic [$clog2(HR_MOD)-1:0]  cur_hr,
    input logic [$clog2(MIN_MOD)-1:0] cur_min,
    input logic [$clog2(HR_MOD)-1:0]  alm_hr,
    input logic [$clog2(MIN_MOD)-1:0] alm_min,
    input logic [$clog2(SEC_MOD)-1:0] tod_sec
);

    localparam int MW = $clog2(MIN_MOD);
    localparam int HW = $clog2(HR_MOD);

    logic one_stb, t_edit, a_edit;
    assign one_stb = inc_stb ^ dec_stb;
    assign t_edit  = one_stb && !fld_sel[1];
    assign a_edit  = one_stb && fld_sel[1];

    a_r1_fields_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_hr) < HR_MOD && int'(cur_min) < MIN_MOD &&
        int'(alm_hr) < HR_MOD && int'(alm_min) < MIN_MOD && int'(tod_sec) < SEC_MOD);

    a_r3_tmin_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (one_stb && inc_stb && fld_sel == 2'd0 && cur_min == MW'(MIN_MOD - 1))
        |=> cur_min == '0);

    a_r3_tmin_dn_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (one_stb && dec_stb && fld_sel == 2'd0 && cur_min == '0)
        |=> cur_min == MW'(MIN_MOD - 1));

    a_r4_ahr_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (one_stb && inc_stb && fld_sel == 2'd3 && alm_hr == HW'(HR_MOD - 1))
        |=> alm_hr == '0);

    a_r5_tmin_edit_keeps_hour: assert property (@(posedge clk) disable iff (!rst_n)
        (one_stb && fld_sel == 2'd0) |=> $stable(cur_hr));

    a_r6_alarm_edit_keeps_time: assert property (@(posedge clk) disable iff (!rst_n)
        (a_edit && !tick_1hz) |=> ($stable(cur_hr) && $stable(cur_min) && $stable(tod_sec)));

    a_r7_tmin_edit_clears_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (one_stb && fld_sel == 2'd0) |=> tod_sec == '0);

    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_mode && !t_edit) |=> ($stable(cur_hr) && $stable(cur_min) && $stable(tod_sec)));

    a_r9_both_strobes_no_edit: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_stb && dec_stb) |=> ($stable(alm_hr) && $stable(alm_min)));

    a_r11_edit_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (t_edit && fld_sel == 2'd1) |=> $stable(tod_sec));

endmodule

bind tod_alarm_regs tar_chk #(
    .SEC_MOD (SEC_MOD),
    .MIN_MOD (MIN_MOD),
    .HR_MOD  (HR_MOD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .run_mode (run_mode),
    .fld_sel  (fld_sel),
    .inc_stb  (inc_stb),
    .dec_stb  (dec_stb),
    .cur_hr   (cur_hr),
    .cur_min  (cur_min),
    .alm_hr   (alm_hr),
    .alm_min  (alm_min),
    .tod_sec  (tod_sec)
);

// File: tb/sim_tod_alarm_regs.sv
`timescale 1ns/1ps
module sim_tod_alarm_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       run_mode = 1'b0;
    logic [1:0] fld_sel = 2'd0;
    logic       inc_stb = 1'b0;
    logic       dec_stb = 1'b0;
    logic [4:0] cur_hr, alm_hr;
    logic [5:0] cur_min, alm_min;
    logic       alm_match;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tod_alarm_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .run_mode  (run_mode),
        .fld_sel   (fld_sel),
        .inc_stb   (inc_stb),
        .dec_stb   (dec_stb),
        .cur_hr    (cur_hr),
        .cur_min   (cur_min),
        .alm_hr    (alm_hr),
        .alm_min   (alm_min),
        .alm_match (alm_match)
    );

    // vector: [27]tick [26]run [25:24]sel [23]inc [22]dec
    //         [21:17]exp hr [16:11]exp min [10:6]exp alarm hr [5:0]exp alarm min
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 5'd0,  6'd0,  5'd1,  6'd0},
        {1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 5'd0,  6'd0,  5'd0,  6'd0},
        {1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 5'd0,  6'd0,  5'd23, 6'd0},
        {1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 5'd0,  6'd0,  5'd23, 6'd59},
        {1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 5'd0,  6'd0,  5'd23, 6'd0},
        {1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 5'd0,  6'd59, 5'd23, 6'd0},
        {1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 5'd0,  6'd0,  5'd23, 6'd0},
        {1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 5'd23, 6'd0,  5'd23, 6'd0},
        {1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 5'd0,  6'd0,  5'd23, 6'd0},
        {1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 5'd0,  6'd0,  5'd23, 6'd0},
        {1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 5'd0,  6'd0,  5'd23, 6'd1},
        {1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 5'd1,  6'd0,  5'd23, 6'd1}
    };
    string vtag [NV] = '{"R4 alarm hour up", "R4 alarm hour down", "R4 alarm hour wrap 0->23",
                         "R3 alarm minute wrap 0->59", "R5 alarm minute wrap no carry",
                         "R5 time minute wrap no borrow", "R3 time minute wrap 59->0",
                         "R4 time hour wrap 0->23", "R4 time hour wrap 23->0",
                         "R9 both strobes", "R6 alarm edit with tick", "R4 time hour up"};

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_time(input string tag, input int hr, input int mn);
        chk({tag, " hour"}, int'(cur_hr), hr);
        chk({tag, " minute"}, int'(cur_min), mn);
    endtask

    // hold inputs for exactly one rising edge, return at the next falling edge
    task automatic cyc(input logic t, input logic r, input logic [1:0] s,
                       input logic i, input logic d);
        tick_1hz = t; run_mode = r; fld_sel = s; inc_stb = i; dec_stb = d;
        @(negedge clk);
        tick_1hz = 1'b0; inc_stb = 1'b0; dec_stb = 1'b0;
    endtask

    task automatic ticks(input int n, input logic r);
        repeat (n) cyc(1'b1, r, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_time("R1 reset time", 0, 0);
        chk("R1 reset alarm hour", int'(alm_hr), 0);
        chk("R1 reset alarm minute", int'(alm_min), 0);
        chk("R1 reset match", int'(alm_match), 1);

        // vector table: R3 R4 R5 R6 R9
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][27], VEC[k][26], VEC[k][25:24], VEC[k][23], VEC[k][22]);
            chk_time(vtag[k], int'(VEC[k][21:17]), int'(VEC[k][16:11]));
            chk({vtag[k], " alarm hour"}, int'(alm_hr), int'(VEC[k][10:6]));
            chk({vtag[k], " alarm minute"}, int'(alm_min), int'(VEC[k][5:0]));
        end
        // time 01:00, seconds 1; alarm 23:01

        // R10 match flag
        cyc(1'b0, 1'b0, 2'd3, 1'b1, 1'b0);   // alarm 00:01
        cyc(1'b0, 1'b0, 2'd3, 1'b1, 1'b0);   // alarm 01:01
        chk("R10 differ by minute", int'(alm_match), 0);
        cyc(1'b0, 1'b0, 2'd2, 1'b0, 1'b1);   // alarm 01:00
        chk("R10 equal", int'(alm_match), 1);
        cyc(1'b0, 1'b0, 2'd2, 1'b1, 1'b0);   // alarm 01:01
        chk("R10 alarm moved away", int'(alm_match), 0);

        // R2 seconds carry into minutes (seconds at 1)
        ticks(58, 1'b1);
        chk_time("R2 before carry", 1, 0);
        ticks(1, 1'b1);
        chk_time("R2 minute carry", 1, 1);
        chk("R10 reached by running", int'(alm_match), 1);

        // R8 stopped clock ignores ticks
        ticks(100, 1'b0);
        chk_time("R8 stopped", 1, 1);

        // R11 hour edit with tick drops the tick; R7 hour edit keeps seconds
        ticks(59, 1'b1);
        cyc(1'b1, 1'b1, 2'd1, 1'b1, 1'b0);
        chk_time("R11 edit wins over tick", 2, 1);
        ticks(1, 1'b1);
        chk_time("R7 R11 seconds kept through hour edit", 2, 2);

        // R7 minute edit clears seconds
        ticks(30, 1'b1);
        cyc(1'b0, 1'b1, 2'd0, 1'b1, 1'b0);
        chk_time("R7 minute edit", 2, 3);
        ticks(59, 1'b1);
        chk_time("R7 seconds restarted", 2, 3);
        ticks(1, 1'b1);
        chk_time("R7 full minute after clear", 2, 4);

        // R2 midnight rollover
        repeat (3) cyc(1'b0, 1'b1, 2'd1, 1'b0, 1'b1);
        repeat (5) cyc(1'b0, 1'b1, 2'd0, 1'b0, 1'b1);
        chk_time("R2 set 23:59", 23, 59);
        ticks(59, 1'b1);
        chk_time("R2 before midnight", 23, 59);
        ticks(1, 1'b1);
        chk_time("R2 midnight rollover", 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule